// File: doc/BRIEF.md
# Host memory window bridge

This block is a host-side slave that gives a narrow 16-bit register bus access to a 32-bit internal address window through a port number and a data word. Behind the window sit two local stores: a store of 16-bit data words and a store of 32-bit instruction words. Software loads the window address in two halves and then reads or writes words through data ports. With the auto-increment option on, a block transfer needs no address reload between words.

Bit 22 of the window address selects the instruction store. Software converts an instruction address to a window address by shifting it left two places and setting bit 22. An instruction word moves as two 16-bit halves. The low half goes through its own port and is staged inside the bridge. The high half goes through the data port shared with the data store, and writing it commits the full 32-bit word. A destructive read-and-clear port returns a data word and zeroes that location in the same access. The bridge also gathers interrupt pulses from the internal side into a pending status register and drives one host interrupt line, gated by an enable bit in the control register.

Top module: `hmw_bridge`

## Requirements
- R1: After reset the window address, the control register and the pending status are all zero, and `host_irq` is low.
- R2: Port numbers on `host_port` are: 0 = address bits 15:0, 1 = address bits 31:16, 2 = shared high data port, 3 = instruction low-half port, 4 = read-and-clear port, 5 = pending status, 6 = control. Writing port 0 or 1 loads only its half of the address, and reading it returns that half.
- R3: When address bit 22 is 0, a port 2 access reads or writes the data-store word at index address[DS_AW-1:0], with the address used as loaded.
- R4: When address bit 22 is 1, port 2 and port 3 reach the instruction-store word at index address[IS_AW+1:2]. This is the word whose instruction address `a` the host mapped as (a<<2)|(1<<22).
- R5: A port 3 write stages the low 16 bits of an instruction word without touching the store. A following port 2 write, with bit 22 set, commits {written high half, staged low half}. A port 3 read returns bits 15:0 of the addressed instruction word, and a port 2 read returns bits 31:16.
- R6: A port 4 read returns the data-store word at address[DS_AW-1:0] and leaves that location at zero. A later read of it returns 0.
- R7: Control bit 1 enables auto-increment. When it is set, the address advances by 1 after each port 2 data-store access and after each port 4 read, and by 4 after each port 2 instruction access. A port 3 access never moves the address. When bit 1 is clear, no data access moves it.
- R8: A 1 on any bit of `irq_set` sets that pending bit. A port 5 write clears each pending bit whose written bit is 0 and keeps those written as 1. A set arriving in the same cycle wins over the clear.
- R9: `host_irq` is high exactly when control bit 0 is set and at least one pending bit is set. With bit 0 clear it stays low whatever is pending.
- R10: Port 7 reads as zero, writes to it change no state, and writes to port 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Read strobe for one cycle, data valid in that cycle |
| host_wr | input | 1 | Write strobe for one cycle, taken at the clock edge |
| host_port | input | 3 | Port number of the access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, zero when no read is active |
| irq_set | input | IRQ_W | Interrupt source pulses from the internal side |
| host_irq | output | 1 | Host interrupt request |

## Verification
The hardest case to reach from the ports is a block transfer that walks through the instruction store. In that transfer the low-half port must leave the address alone while the high-half port moves it by four, and a wrong step only shows up words later as data in the wrong slot. The stimulus fills both stores completely through auto-incremented transfers from a single address load. It then reads blocks back from remapped addresses and watches the address through its read-back ports. A second difficult case is a pending bit that is set in the same cycle as a status clear. The bench pulses a source during a write of zeros and then checks that the bit survived.

// File: rtl/hmw_pkg.sv
package hmw_pkg;
   localparam int HOST_W   = 16;
   localparam int WIN_W    = 32;
   localparam int ISEL_BIT = 22;
   localparam int CTRL_W   = 2;
   localparam int CTRL_IRQ_EN = 0;
   localparam int CTRL_AINC   = 1;

   typedef enum logic [2:0] {
      P_ADDR_LO  = 3'd0,
      P_ADDR_HI  = 3'd1,
      P_DATA_HI  = 3'd2,
      P_DATA_LO  = 3'd3,
      P_RDCLR    = 3'd4,
      P_IRQ_STAT = 3'd5,
      P_CTRL     = 3'd6,
      P_SPARE    = 3'd7
   } port_e;
endpackage

// File: rtl/hmw_win_addr.sv
module hmw_win_addr #(
   parameter int HW = 16,
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_lo,
   input  logic          ld_hi,
   input  logic [HW-1:0] wdata,
   input  logic          adv,
   input  logic          adv_by4,
   output logic [AW-1:0] addr
);
   localparam logic [AW-1:0] STEP1 = AW'(1);
   localparam logic [AW-1:0] STEP4 = AW'(4);

   if (AW != 2 * HW) begin : g_bad_width
      $error("hmw_win_addr: window width must be twice the host width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr <= '0;
      else if (ld_lo)
         addr[HW-1:0] <= wdata;
      else if (ld_hi)
         addr[AW-1:HW] <= wdata;
      else if (adv)
         addr <= addr + (adv_by4 ? STEP4 : STEP1);
   end
endmodule

// File: rtl/hmw_dstore.sv
module hmw_dstore #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we,
   input  logic          clr,
   input  logic [AW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[idx] <= wdata;
      else if (clr)
         mem[idx] <= '0;
   end

   assign rdata = mem[idx];
endmodule

// File: rtl/hmw_istore.sv
module hmw_istore #(
   parameter int AW = 6,
   parameter int HW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stage_we,
   input  logic            commit,
   input  logic [AW-1:0]   idx,
   input  logic [HW-1:0]   wdata,
   output logic [2*HW-1:0] rd_word
);
   localparam int DEPTH = 1 << AW;

   logic [2*HW-1:0] mem [DEPTH];
   logic [HW-1:0]   stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         stage_q <= '0;
      else if (stage_we)
         stage_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (commit)
         mem[idx] <= {wdata, stage_q};
   end

   assign rd_word = mem[idx];
endmodule

// File: rtl/hmw_irq.sv
module hmw_irq #(
   parameter int W          = 16,
   parameter bit REGISTERED = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         wr_en,
   input  logic [W-1:0] keep_mask,
   input  logic         en,
   output logic [W-1:0] status,
   output logic         irq_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         status <= '0;
      else
         status <= (wr_en ? (status & keep_mask) : status) | set_i;
   end

   if (REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= en & (|status);
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = en & (|status);
   end
endmodule

// File: rtl/hmw_bridge.sv
module hmw_bridge #(
   parameter int DS_AW   = 8,
   parameter int IS_AW   = 6,
   parameter int IRQ_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_rd,
   input  logic                       host_wr,
   input  logic [2:0]                 host_port,
   input  logic [hmw_pkg::HOST_W-1:0] host_wdata,
   output logic [hmw_pkg::HOST_W-1:0] host_rdata,
   input  logic [IRQ_W-1:0]           irq_set,
   output logic                       host_irq
);
   import hmw_pkg::*;

   if (DS_AW < 1 || DS_AW > ISEL_BIT) begin : g_bad_ds
      $error("hmw_bridge: DS_AW out of range");
   end
   if (IS_AW < 1 || IS_AW + 2 > ISEL_BIT) begin : g_bad_is
      $error("hmw_bridge: IS_AW overlaps the store select bit");
   end
   if (IRQ_W < 1 || IRQ_W > HOST_W) begin : g_bad_irq
      $error("hmw_bridge: IRQ_W wider than the host bus");
   end

   port_e               port;
   logic                acc_rd, acc_wr;
   logic [WIN_W-1:0]    win_addr;
   logic                is_sel;
   logic [CTRL_W-1:0]   ctrl_q;
   logic                ainc, irq_en;
   logic                hi_acc, rc_acc;
   logic [HOST_W-1:0]   ds_rdata;
   logic [2*HOST_W-1:0] is_word;
   logic [IRQ_W-1:0]    status;

   assign port   = port_e'(host_port);
   assign acc_wr = host_wr;
   assign acc_rd = host_rd & ~host_wr;
   assign is_sel = win_addr[ISEL_BIT];
   assign ainc   = ctrl_q[CTRL_AINC];
   assign irq_en = ctrl_q[CTRL_IRQ_EN];
   assign hi_acc = (acc_rd | acc_wr) && (port == P_DATA_HI);
   assign rc_acc = acc_rd && (port == P_RDCLR);

   hmw_win_addr #(.HW(HOST_W), .AW(WIN_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo   (acc_wr && port == P_ADDR_LO),
      .ld_hi   (acc_wr && port == P_ADDR_HI),
      .wdata   (host_wdata),
      .adv     (ainc && (hi_acc || rc_acc)),
      .adv_by4 (hi_acc && is_sel),
      .addr    (win_addr)
   );

   hmw_dstore #(.AW(DS_AW), .DW(HOST_W)) u_ds (
      .clk   (clk),
      .we    (acc_wr && port == P_DATA_HI && !is_sel),
      .clr   (rc_acc),
      .idx   (win_addr[DS_AW-1:0]),
      .wdata (host_wdata),
      .rdata (ds_rdata)
   );

   hmw_istore #(.AW(IS_AW), .HW(HOST_W)) u_is (
      .clk      (clk),
      .rst_n    (rst_n),
      .stage_we (acc_wr && port == P_DATA_LO),
      .commit   (acc_wr && port == P_DATA_HI && is_sel),
      .idx      (win_addr[IS_AW+1:2]),
      .wdata    (host_wdata),
      .rd_word  (is_word)
   );

   hmw_irq #(.W(IRQ_W), .REGISTERED(IRQ_REG)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (irq_set),
      .wr_en     (acc_wr && port == P_IRQ_STAT),
      .keep_mask (host_wdata[IRQ_W-1:0]),
      .en        (irq_en),
      .status    (status),
      .irq_o     (host_irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (acc_wr && port == P_CTRL)
         ctrl_q <= host_wdata[CTRL_W-1:0];
   end

   always_comb begin
      host_rdata = '0;
      if (acc_rd) begin
         case (port)
            P_ADDR_LO:  host_rdata = win_addr[HOST_W-1:0];
            P_ADDR_HI:  host_rdata = win_addr[WIN_W-1:HOST_W];
            P_DATA_HI:  host_rdata = is_sel ? is_word[2*HOST_W-1:HOST_W] : ds_rdata;
            P_DATA_LO:  host_rdata = is_word[HOST_W-1:0];
            P_RDCLR:    host_rdata = ds_rdata;
            P_IRQ_STAT: host_rdata = HOST_W'(status);
            P_CTRL:     host_rdata = HOST_W'(ctrl_q);
            default:    host_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/hmw_bridge_chk.sv
module hmw_bridge_chk #(
   parameter int IRQ_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_rd,
   input logic             host_wr,
   input logic [2:0]       host_port,
   input logic [15:0]      host_wdata,
   input logic [IRQ_W-1:0] irq_set,
   input logic             host_irq,
   input logic [31:0]      win_addr,
   input logic             ainc,
   input logic             irq_en,
   input logic [IRQ_W-1:0] status
);
   logic data_acc;
   assign data_acc = (host_rd || host_wr) && host_port == 3'd2;

   // R7
   addr_step1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && ainc && !win_addr[22]) |=> win_addr == $past(win_addr) + 32'd1);

   // R7
   addr_step4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && ainc && win_addr[22]) |=> win_addr == $past(win_addr) + 32'd4);

   // R5
   lo_half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_rd || host_wr) && host_port == 3'd3) |=> $stable(win_addr));

   // R9
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !$past(irq_en)) |-> !host_irq);

   // R8
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_port == 3'd5 && irq_set == '0)
      |=> status == ($past(status) & $past(host_wdata[IRQ_W-1:0])));

   // R8
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(host_wr && host_port == 3'd5) && irq_set == '0) |=> $stable(status));
endmodule

bind hmw_bridge hmw_bridge_chk #(.IRQ_W(IRQ_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_rd    (host_rd),
   .host_wr    (host_wr),
   .host_port  (host_port),
   .host_wdata (host_wdata),
   .irq_set    (irq_set),
   .host_irq   (host_irq),
   .win_addr   (win_addr),
   .ainc       (ainc),
   .irq_en     (irq_en),
   .status     (status)
);

// File: tb/tb_hmw_bridge.sv
module tb_hmw_bridge;
   localparam int DS_AW = 8;
   localparam int IS_AW = 6;
   localparam int IRQ_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_rd = 1'b0, host_wr = 1'b0;
   logic [2:0]        host_port = 3'd7;
   logic [15:0]       host_wdata = '0;
   logic [15:0]       host_rdata;
   logic [IRQ_W-1:0]  irq_set = '0;
   logic              host_irq;

   hmw_bridge #(.DS_AW(DS_AW), .IS_AW(IS_AW), .IRQ_W(IRQ_W)) dut (
      .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
      .host_port(host_port), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq_set(irq_set), .host_irq(host_irq)
   );

   always #5 clk = ~clk;

   // reference model state
   logic [31:0] m_addr = '0;
   logic [15:0] m_ds [1 << DS_AW];
   logic [31:0] m_is [1 << IS_AW];
   logic [15:0] m_stage = '0;
   logic [15:0] m_stat = '0;
   logic [1:0]  m_ctrl = '0;
   int n_cmp = 0, n_bad = 0, cycles = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] m_read(input logic [2:0] p);
      case (p)
         3'd0: return m_addr[15:0];
         3'd1: return m_addr[31:16];
         3'd2: return m_addr[22] ? m_is[m_addr[IS_AW+1:2]][31:16] : m_ds[m_addr[DS_AW-1:0]];
         3'd3: return m_is[m_addr[IS_AW+1:2]][15:0];
         3'd4: return m_ds[m_addr[DS_AW-1:0]];
         3'd5: return m_stat;
         3'd6: return {14'd0, m_ctrl};
         default: return 16'd0;
      endcase
   endfunction

   task automatic m_apply(input bit r, input bit w, input logic [2:0] p,
                          input logic [15:0] d, input logic [15:0] s);
      int step;
      step = 0;
      if (w) begin
         case (p)
            3'd0: m_addr[15:0] = d;
            3'd1: m_addr[31:16] = d;
            3'd2: begin
               if (m_addr[22]) begin m_is[m_addr[IS_AW+1:2]] = {d, m_stage}; step = 4; end
               else begin m_ds[m_addr[DS_AW-1:0]] = d; step = 1; end
            end
            3'd3: m_stage = d;
            3'd5: m_stat = m_stat & d;
            3'd6: m_ctrl = d[1:0];
            default: ;
         endcase
      end else if (r) begin
         if (p == 3'd2) step = m_addr[22] ? 4 : 1;
         if (p == 3'd4) begin m_ds[m_addr[DS_AW-1:0]] = '0; step = 1; end
      end
      m_stat = m_stat | s;
      if (m_ctrl_prev_ainc && step != 0) m_addr = m_addr + 32'(step);
   endtask

   bit m_ctrl_prev_ainc;

   // one bus cycle: drive after the edge, compare at the falling edge, update model at the edge
   task automatic op(input bit r, input bit w, input logic [2:0] p,
                     input logic [15:0] d, input logic [15:0] s, input string req);
      logic [15:0] exp;
      host_rd = r; host_wr = w; host_port = p; host_wdata = d; irq_set = s;
      exp = m_read(p);
      @(negedge clk);
      if (r) chk({req, " rdata"}, host_rdata, exp);
      chk({req, " irq"}, {15'd0, host_irq}, {15'd0, (m_ctrl[0] && m_stat != 0)});
      @(posedge clk);
      m_ctrl_prev_ainc = m_ctrl[1];
      m_apply(r, w, p, d, s);
      #1;
      host_rd = 0; host_wr = 0; host_port = 3'd7; irq_set = '0;
   endtask

   task automatic wr(input logic [2:0] p, input logic [15:0] d, input string req);
      op(0, 1, p, d, '0, req);
   endtask
   task automatic rd(input logic [2:0] p, input string req);
      op(1, 0, p, '0, '0, req);
   endtask
   task automatic set_addr(input logic [31:0] a, input string req);
      wr(3'd0, a[15:0], req);
      wr(3'd1, a[31:16], req);
   endtask
   function automatic logic [31:0] imap(input int ia);
      return (32'(ia) << 2) | (32'd1 << 22);
   endfunction

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual %0d expected below 100000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      rd(3'd0, "R1 addr lo");
      rd(3'd1, "R1 addr hi");
      rd(3'd5, "R1 status");
      rd(3'd6, "R1 ctrl");

      // R2 address halves load independently
      wr(3'd0, 16'h1234, "R2");
      rd(3'd1, "R2 hi untouched");
      wr(3'd1, 16'hBEEF, "R2");
      rd(3'd0, "R2 lo");
      rd(3'd1, "R2 hi");

      // R7 auto-increment on; fill data store in one block (R3)
      wr(3'd6, 16'h0002, "R7 ctrl");
      set_addr(32'd0, "R3");
      for (int i = 0; i < (1 << DS_AW); i++)
         wr(3'd2, 16'((i * 37 + 5) ^ 16'hA5A5), "R3 fill");
      rd(3'd0, "R7 addr after data block");

      // R4 R5 fill instruction store in one block
      set_addr(imap(0), "R4");
      for (int i = 0; i < (1 << IS_AW); i++) begin
         wr(3'd3, 16'(i * 13 + 7), "R5 stage");
         rd(3'd0, "R7 lo port keeps addr");
         wr(3'd2, 16'(16'hC000 + i * 3), "R5 commit");
      end
      rd(3'd0, "R7 addr after instr block");
      rd(3'd1, "R4 select bit kept");

      // R3 R7 block read of data
      set_addr(32'd10, "R3");
      for (int i = 0; i < 8; i++) rd(3'd2, "R3 R7 data block read");
      rd(3'd0, "R7 addr step 1");

      // R4 R5 remapped instruction reads
      set_addr(imap(5), "R4");
      rd(3'd3, "R5 low half");
      rd(3'd3, "R7 low half no advance");
      rd(3'd2, "R5 high half");
      rd(3'd3, "R4 next word low");
      rd(3'd2, "R4 next word high");
      set_addr(imap(63), "R4");
      rd(3'd3, "R4 last word low");
      rd(3'd2, "R4 last word high");

      // R7 auto-increment off
      wr(3'd6, 16'h0000, "R7 ctrl off");
      set_addr(32'd40, "R7");
      rd(3'd2, "R7 off read");
      rd(3'd2, "R7 off same word");
      wr(3'd2, 16'h5A5A, "R7 off write");
      rd(3'd0, "R7 off addr held");
      rd(3'd2, "R3 written word");

      // R6 read-and-clear
      set_addr(32'd20, "R6");
      rd(3'd4, "R6 returns word");
      rd(3'd2, "R6 zeroed");
      wr(3'd4, 16'h7777, "R10 rdclr write ignored");
      rd(3'd2, "R10 still zero");
      wr(3'd6, 16'h0002, "R7 ctrl on");
      set_addr(32'd30, "R6");
      for (int i = 0; i < 3; i++) rd(3'd4, "R6 R7 block rdclr");
      set_addr(32'd30, "R6");
      for (int i = 0; i < 3; i++) rd(3'd2, "R6 block zeroed");

      // R8 R9 interrupts
      op(0, 0, 3'd7, '0, 16'h0005, "R8 set");
      rd(3'd5, "R8 pending");
      rd(3'd6, "R9 masked");
      wr(3'd6, 16'h0003, "R9 enable");
      rd(3'd5, "R9 unmasked");
      wr(3'd5, 16'hFFFE, "R8 clear bit0");
      rd(3'd5, "R8 bit2 left");
      wr(3'd5, 16'hFFFB, "R8 clear bit2");
      rd(3'd5, "R9 none pending");
      op(0, 1, 3'd5, 16'h0000, 16'h0008, "R8 set wins");
      rd(3'd5, "R8 bit3 kept");
      wr(3'd6, 16'h0002, "R9 disable");
      rd(3'd5, "R9 masked again");
      wr(3'd5, 16'hFFF7, "R8 clear bit3");

      // R10 spare port
      wr(3'd7, 16'hFFFF, "R10 spare write");
      rd(3'd6, "R10 ctrl unchanged");
      rd(3'd7, "R10 spare reads zero");
      rd(3'd0, "R10 addr unchanged");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule